// File: doc/BRIEF.md
# Clock-Enable Divider Bank with Grouped Commit

This block derives several slower clock-enable streams from one fast input clock. Every channel has its own programmable divide value and its own enable. Each enabled channel emits a pulse one input cycle wide, once per period. Software reaches the block through a small register port. It writes new divide settings into per-channel staging registers, and those writes leave the running outputs alone.

To put the staged settings into effect, software writes the commit bit of the command register. The block takes a copy of every staged setting and raises a busy flag. It then waits for the first input-clock edge at which every running channel is in the last cycle of its current period. At that single edge it switches all channels to the new settings together, restarts their counters side by side, and drops the busy flag. Because of this, no output ever delivers a truncated period across a ratio change. Software is expected to poll the busy flag before staging new values, and to poll it again after a commit until it reads clear.

Top module: `clkdiv_bank`

## Requirements
- R1: After a synchronous reset every `div_ce` output is low, the status flag reads 0, and every divider register reads 0.
- R2: Divider register k sits at address 2+k. A write stores bits [4:0] as the ratio field N and bit 15 as the enable. Reading the register returns those two fields and returns zero in bits [14:5].
- R3: Writing a divider register changes no `div_ce` output until a commit is applied.
- R4: Address 0 is the command register. Writing it with bit 0 set starts a commit, and the status register (address 1) reads bit 0 = 1 from the next cycle on. Writing bit 0 = 0 does nothing. The command register always reads 0, and unmapped addresses read 0.
- R5: A pending commit is applied at the first clock edge at which every enabled channel is in the final cycle of its period, or at the next edge if no channel is enabled. The status bit clears at that same edge.
- R6: At the apply edge all channels take their committed settings together and restart their periods, so the first new pulse of a channel with ratio N comes N+1 cycles after that edge.
- R7: An enabled channel with ratio N (0..31) drives `div_ce` high for exactly one cycle out of every N+1, in the last cycle of each period.
- R8: A disabled channel holds its `div_ce` low.
- R9: Divider writes made while the status bit is set reach only the staging register. The pending commit does not carry them; a later commit does.
- R10: A commit request written while the status bit is set is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock (PLL output) |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register address for both reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| div_ce | output | NUM_DIV | Per-channel clock-enable pulses |

## Verification
A corrupted period counter shows up as a `div_ce` pulse that is misplaced, missing or extra. For an enabled channel this appears within one period of N+1 cycles. If a stuck counter or a wrong end-of-period term corrupts the alignment check, the commit lands on the wrong edge or never lands. That shows as the status bit clearing early or staying set, and every channel's pulse phase then shifts relative to a cycle-exact arithmetic model. If the staged copy has the wrong contents, the error stays hidden until the apply edge. From then on the wrong period or enable is visible on every pulse.

// File: rtl/clkdiv_pkg.sv
// Shared constants and types for the clock-enable divider bank.
// Assumes one ratio field width for all channels; register addresses are fixed.
package clkdiv_pkg;
    localparam int RATIO_W   = 5;   // ratio field N, divide value N+1
    localparam int ADDR_CMD  = 0;   // command register, bit 0 = commit
    localparam int ADDR_STAT = 1;   // status register, bit 0 = busy
    localparam int ADDR_DIV0 = 2;   // first divider register

    // One channel's divide setting
    typedef struct packed {
        logic               en;
        logic [RATIO_W-1:0] ratio;
    } div_cfg_t;
endpackage

// File: rtl/clkdiv_regs.sv
// Register file of the divider bank: per-channel staging registers, the
// commit strobe decode and the combinational read mux.
// Assumes one write per cycle; the enable bit sits in the top data bit.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    input  logic                      busy,
    output logic                      go_req,
    output div_cfg_t [NUM_DIV-1:0]    shadow,
    output logic [DATA_W-1:0]         reg_rdata
);
    localparam int EN_BIT = DATA_W - 1;

    // Data bits that no field stores
    logic unused_wdata_bits;
    assign unused_wdata_bits = ^reg_wdata[EN_BIT-1:RATIO_W];

    // Commit request: command write with bit 0 set
    assign go_req = reg_wr && (reg_addr == ADDR_W'(ADDR_CMD)) && reg_wdata[0];

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_shadow
        // Load one channel's staging register on a write to its address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[i] <= '0;
            end else if (reg_wr && reg_addr == ADDR_W'(ADDR_DIV0 + i)) begin
                shadow[i].en    <= reg_wdata[EN_BIT];
                shadow[i].ratio <= reg_wdata[RATIO_W-1:0];
            end
        end

        p_shadow_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(ADDR_DIV0 + i)) |=>
                (shadow[i].ratio == $past(reg_wdata[RATIO_W-1:0]) &&
                 shadow[i].en == $past(reg_wdata[EN_BIT])));
    end

    // Read mux: status, staging registers, zero elsewhere
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata[0] = busy;
        end
        for (int i = 0; i < NUM_DIV; i++) begin
            if (reg_addr == ADDR_W'(ADDR_DIV0 + i)) begin
                reg_rdata[EN_BIT]        = shadow[i].en;
                reg_rdata[RATIO_W-1:0]   = shadow[i].ratio;
            end
        end
    end
endmodule

// File: rtl/clkdiv_commit.sv
// Commit controller: captures the staged settings on a commit request,
// holds busy, and applies them when every running channel ends its period.
// Assumes all_at_end is already true for disabled channels.
module clkdiv_commit
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go_req,
    input  div_cfg_t [NUM_DIV-1:0]    shadow,
    input  logic                      all_at_end,
    output logic                      busy,
    output logic                      apply,
    output div_cfg_t [NUM_DIV-1:0]    active
);
    div_cfg_t [NUM_DIV-1:0] staged;

    assign apply = busy && all_at_end;

    // Busy flag: set on an accepted request, cleared at the apply edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (busy) begin
            if (all_at_end) busy <= 1'b0;
        end else if (go_req) begin
            busy <= 1'b1;
        end
    end

    // Staged copy: taken only when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else if (go_req && !busy) begin
            staged <= shadow;
        end
    end

    // Running settings: replaced as a group at the apply edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (apply) begin
            active <= staged;
        end
    end

    p_go_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !busy) |=> busy);

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !all_at_end) |=> (busy && $stable(staged) && $stable(active)));

    p_apply_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (!busy && active == $past(staged)));
endmodule

// File: rtl/clkdiv_chan.sv
// One divider channel: counts 0..N and pulses ce in the last cycle.
// Assumes restart coincides with any change of cfg.
module clkdiv_chan
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_cfg_t cfg,
    input  logic     restart,
    output logic     ce,
    output logic     at_end
);
    logic [RATIO_W-1:0] cnt;
    logic               last;

    assign last   = (cnt == cfg.ratio);
    assign ce     = cfg.en && last;
    assign at_end = !cfg.en || last;

    // Period counter: wraps after N, parked at zero when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !cfg.en) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.en |-> (cnt <= cfg.ratio));

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    p_idle_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (cnt == '0));
endmodule

// File: rtl/clkdiv_bank.sv
// Top of the clock-enable divider bank: register file, commit controller
// and one counter channel per output.
// Assumes a single clock domain; reads are combinational on reg_addr.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_DIV-1:0] div_ce
);
    div_cfg_t [NUM_DIV-1:0] shadow;
    div_cfg_t [NUM_DIV-1:0] active;
    logic [NUM_DIV-1:0]     at_end;
    logic                   go_req;
    logic                   busy;
    logic                   apply;
    logic                   all_at_end;

    assign all_at_end = &at_end;

    clkdiv_regs #(.NUM_DIV(NUM_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .go_req    (go_req),
        .shadow    (shadow),
        .reg_rdata (reg_rdata)
    );

    clkdiv_commit #(.NUM_DIV(NUM_DIV)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_req     (go_req),
        .shadow     (shadow),
        .all_at_end (all_at_end),
        .busy       (busy),
        .apply      (apply),
        .active     (active)
    );

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_chan
        clkdiv_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (active[i]),
            .restart (apply),
            .ce      (div_ce[i]),
            .at_end  (at_end[i])
        );
    end

    p_ce_only_when_idle_or_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && |div_ce && !all_at_end) |=> busy);

    p_busy_needs_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_req));
endmodule

// File: tb/test_clkdiv_bank.sv
// Self-checking bench: a cycle-exact arithmetic model runs beside the design.
module test_clkdiv_bank;
    localparam int NDIV = 4;
    localparam int AW   = 4;
    localparam int DW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = 4'd1;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NDIV-1:0] div_ce;

    int checks = 0;
    int errors = 0;
    int wd = 0;

    clkdiv_bank #(.NUM_DIV(NDIV), .ADDR_W(AW), .DATA_W(DW)) i_clkdiv_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_ce(div_ce)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Arithmetic model state
    int  k = 0;
    int  origin = 0;
    bit  m_valid = 0;
    bit  m_busy = 0;
    bit  was_busy;
    bit  bnd;
    int  sh_r [NDIV];
    bit  sh_e [NDIV];
    int  st_r [NDIV];
    bit  st_e [NDIV];
    int  ac_r [NDIV];
    bit  ac_e [NDIV];

    // Model update at each edge, from the inputs held across that edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NDIV; i++) begin
                sh_r[i] = 0; sh_e[i] = 0; st_r[i] = 0; st_e[i] = 0;
                ac_r[i] = 0; ac_e[i] = 0;
            end
            m_busy = 0;
            origin = k + 1;
            m_valid = 1;
        end else begin
            bnd = 1;
            for (int i = 0; i < NDIV; i++)
                if (ac_e[i] && ((k - origin) % (ac_r[i] + 1)) != ac_r[i]) bnd = 0;
            was_busy = m_busy;
            if (m_busy && bnd) begin
                for (int i = 0; i < NDIV; i++) begin ac_r[i] = st_r[i]; ac_e[i] = st_e[i]; end
                origin = k + 1;
                m_busy = 0;
            end
            if (reg_wr) begin
                if (reg_addr >= 2 && reg_addr < 2 + NDIV) begin
                    sh_r[reg_addr-2] = int'(reg_wdata[4:0]);
                    sh_e[reg_addr-2] = reg_wdata[15];
                end else if (reg_addr == 0 && reg_wdata[0] && !was_busy) begin
                    for (int i = 0; i < NDIV; i++) begin st_r[i] = sh_r[i]; st_e[i] = sh_e[i]; end
                    m_busy = 1;
                end
            end
        end
        k = k + 1;
    end

    // Continuous comparison, mid-cycle
    always @(negedge clk) begin
        if (m_valid) begin
            logic [NDIV-1:0] exp_ce;
            logic [DW-1:0]   exp_rd;
            for (int i = 0; i < NDIV; i++)
                exp_ce[i] = ac_e[i] && (((k - origin) % (ac_r[i] + 1)) == ac_r[i]);
            exp_rd = '0;
            if (reg_addr == 1) exp_rd[0] = m_busy;
            if (reg_addr >= 2 && reg_addr < 2 + NDIV) begin
                exp_rd[15]  = sh_e[reg_addr-2];
                exp_rd[4:0] = 5'(sh_r[reg_addr-2]);
            end
            checks++;
            if (div_ce !== exp_ce) begin
                errors++;
                $display("FAIL R3/R5/R6/R7/R8 div_ce actual %b expected %b cycle %0d", div_ce, exp_ce, k);
            end
            checks++;
            if (reg_rdata !== exp_rd) begin
                errors++;
                $display("FAIL R2/R4/R5 rdata actual %h expected %h cycle %0d", reg_rdata, exp_rd, k);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL R5 watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = AW'(1); reg_wdata = '0;
    endtask

    task automatic rd_reg(input int a, output int v);
        @(posedge clk); #1;
        reg_addr = AW'(a);
        @(negedge clk);
        v = int'(reg_rdata);
        @(posedge clk); #1;
        reg_addr = AW'(1);
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (reg_rdata[0] && t < 5000) begin @(negedge clk); t++; end
        chk("R5 busy clears", (t < 5000) ? 1 : 0, 1);
    endtask

    task automatic count_ce(input int ch, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (div_ce[ch]) c++;
            @(negedge clk);
        end
    endtask

    initial begin
        int v;
        int c;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ce after reset", int'(div_ce), 0);
        chk("R1 status after reset", int'(reg_rdata[0]), 0);
        for (int a = 2; a < 2 + NDIV; a++) begin
            rd_reg(a, v);
            chk("R1 divider reads zero", v, 0);
        end

        // R2 field packing and ignored bits
        wr_reg(3, 16'hFFFF);
        rd_reg(3, v); chk("R2 readback all ones", v, 16'h801F);
        wr_reg(3, 16'h7FE5);
        rd_reg(3, v); chk("R2 readback upper ignored", v, 16'h0005);
        rd_reg(15, v); chk("R4 unmapped reads zero", v, 0);

        // R4 zero write to command does nothing
        wr_reg(0, 16'hFFFE);
        @(negedge clk); chk("R4 no commit on bit0=0", int'(reg_rdata[0]), 0);
        rd_reg(0, v); chk("R4 command reads zero", v, 0);

        // R3 staged write without commit
        wr_reg(2, 16'h8003);
        @(negedge clk);
        count_ce(0, 40, c); chk("R3 no output before commit", c, 0);

        // R4 commit raises busy next cycle
        wr_reg(0, 1);
        @(negedge clk); chk("R4 busy after commit", int'(reg_rdata[0]), 1);
        wait_idle();
        count_ce(0, 12, c); chk("R6 first periods after apply", c, 3);

        // Sweep every ratio on every channel, others disabled
        for (int ch = 0; ch < NDIV; ch++) begin
            for (int j = 0; j < NDIV; j++) wr_reg(2 + j, 0);
            for (int n = 0; n < 32; n++) begin
                wr_reg(2 + ch, 16'h8000 | n);
                wr_reg(0, 1);
                wait_idle();
                count_ce(ch, 3 * (n + 1), c);
                chk("R7 pulses per three periods", c, 3);
                chk("R8 disabled channels low", int'(div_ce & ~(NDIV'(1) << ch)), 0);
            end
        end

        // Mixed ratios, all enabled
        wr_reg(2, 16'h8001); wr_reg(3, 16'h8002); wr_reg(4, 16'h8003); wr_reg(5, 16'h8005);
        wr_reg(0, 1); wait_idle();
        count_ce(3, 60, c); chk("R7 ratio 5 in 60 cycles", c, 10);
        wr_reg(2, 16'h801F); wr_reg(3, 16'h800F); wr_reg(4, 16'h8007); wr_reg(5, 16'h8003);
        wr_reg(0, 1); wait_idle();
        count_ce(0, 96, c); chk("R6 ratio 31 after group switch", c, 3);

        // R9 / R10: long commit window, writes and second request while busy
        wr_reg(2, 16'h801E); wr_reg(3, 16'h801C); wr_reg(4, 0); wr_reg(5, 0);
        wr_reg(0, 1); wait_idle();
        repeat (7) @(negedge clk);
        wr_reg(2, 16'h8002);
        wr_reg(0, 1);
        @(negedge clk); chk("R9 busy during window", int'(reg_rdata[0]), 1);
        wr_reg(4, 16'h8004);
        wr_reg(0, 1);
        wait_idle();
        count_ce(2, 20, c); chk("R9 R10 late write not applied", c, 0);
        count_ce(0, 21, c); chk("R6 committed ratio 2", c, 7);
        wr_reg(0, 1); wait_idle();
        count_ce(2, 20, c); chk("R9 applied by later commit", c, 4);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule